// File: doc/BRIEF.md
# Serial Result Streamer for a Successive-Approximation Converter

This block is the serial-mode digital front end of a 12-bit successive-approximation converter. A falling edge on the active-low chip select starts a conversion. The converter core decides one result bit at a time and reports each one on `bit_valid` / `bit_val`. The block places each bit on `dout` as soon as it has been decided, so the result streams out while the conversion is still running. The block also produces a serial clock (`sclk_out`) and a frame strobe (`sstrb`) that a receiver uses to capture the stream.

All logic runs on `clk`, the converter clock. One bit period spans two `clk` cycles. `sclk_out` is low for the first cycle of a bit period and high for the second, so data changes on the falling edge of `sclk_out` and is sampled on the rising edge. A frame has 13 bit periods: one strobe period, then the 12 result bits with the most significant bit first.

Each of the three outputs has its own output enable. The enables follow the chip-select and read inputs directly. The high-byte select input `hben` decides whether `sclk_out` also runs between conversions.

Top module: `sar_serial_tx`

## Requirements
- R1: When `cs_n` is sampled high on one `clk` edge and low on the next, and no conversion is running, that second edge starts a conversion. `conv_start` is high for exactly the one cycle after that edge.
- R2: `sstrb` is high for the whole first bit period of a frame (the two cycles after the start edge) and is low at all other times.
- R3: During a conversion, `sclk_out` is 0 in the first cycle and 1 in the second cycle of each bit period. A conversion spans 13 bit periods (26 `clk` cycles).
- R4: In bit period p (p = 1 to 12, counted from 0 at the strobe period), `dout` carries result bit 12-p, so the MSB comes first. The value shown is the one given by the most recent `bit_valid` pulse seen up to and including the edge that opens the period.
- R5: `dout` is 0 during the strobe period and whenever no conversion is running.
- R6: While no conversion runs, `sclk_out` is 0 if `hben` is 0. If `hben` is 1 and `cs_n` is 0, `sclk_out` toggles on every `clk` edge, starting at 1 on the first edge after a frame ends.
- R7: `dout_oe` is the inverse of `cs_n`. `sclk_oe` and `sstrb_oe` are 1 only when both `cs_n` and `rd_n` are 0. All enables respond to their inputs without waiting for a clock.
- R8: A falling edge on `cs_n` while a conversion runs is ignored. It neither restarts nor disturbs the frame, and it does not start a conversion after the frame ends.
- R9: While `rst_n` is 0, `conv_start`, `dout`, `sclk_out` and `sstrb` are 0 and any running conversion is abandoned.
- R10: After a frame's 13th bit period the block is idle. The next valid `cs_n` falling edge starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; its falling edge starts a conversion |
| rd_n | input | 1 | Active-low read; gates the clock and strobe enables |
| hben | input | 1 | 1 = serial clock also runs between conversions |
| bit_valid | input | 1 | Pulse from the converter core: a result bit has been decided |
| bit_val | input | 1 | Value of the decided bit |
| conv_start | output | 1 | One-cycle pulse telling the core to begin a conversion |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| sclk_out | output | 1 | Serial clock to the receiver |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| sstrb | output | 1 | Frame strobe, high for the bit period before the MSB |
| sstrb_oe | output | 1 | Output enable for `sstrb` |

## Verification
A wrong phase bit or period counter inside the frame sequencer shows up within one `clk` cycle: `sclk_out` fails to alternate, or `sstrb` stays high past its two cycles. A period counter that is off by one places the wrong result bit on `dout` at the very next falling serial clock, and moves the frame end, and with it the return to a quiet or free-running `sclk_out`, by a whole bit period. A stale chip-select history register appears as a missing or spurious `conv_start` on the edge after `cs_n` falls.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_st_e;

    // Per-edge events from the frame sequencer to the data path
    typedef struct packed {
        logic frame_start;  // this edge opens a frame (strobe period)
        logic slot_edge;    // this edge opens a data bit period
        logic frame_end;    // this edge closes the frame
    } seq_evt_t;

endpackage

// File: rtl/sps_start_det.sv
module sps_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic busy,
    output logic start
);

    typedef struct packed {
        logic cs_prev;
    } det_t;

    det_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.cs_prev = cs_n;
        // falling select edge, honoured only when idle
        start       = r_q.cs_prev & ~cs_n & ~busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cs_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/sps_seq.sv
module sps_seq
    import sps_pkg::*;
#(
    parameter int NBITS = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     hben,
    input  logic     cs_n,
    output logic     busy,
    output logic     sclk_out,
    output logic     sstrb,
    output logic     conv_start,
    output seq_evt_t evt
);

    localparam int PW = $clog2(NBITS + 1);
    localparam logic [PW-1:0] LAST_PER = PW'(NBITS);

    typedef struct packed {
        seq_st_e       st;
        logic          ph;      // 0: low half of bit period, 1: high half
        logic [PW-1:0] per;     // bit period index, 0 = strobe period
        logic          strobe;
        logic          go;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        evt    = '0;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    r_d.st          = SEQ_CONV;
                    r_d.ph          = 1'b0;
                    r_d.per         = '0;
                    r_d.strobe      = 1'b1;
                    r_d.go          = 1'b1;
                    evt.frame_start = 1'b1;
                end else begin
                    r_d.ph = (hben & ~cs_n) ? ~r_q.ph : 1'b0;
                end
            end
            SEQ_CONV: begin
                if (!r_q.ph) begin
                    r_d.ph = 1'b1;
                end else if (r_q.per == LAST_PER) begin
                    r_d.st        = SEQ_IDLE;
                    r_d.ph        = 1'b0;
                    r_d.per       = '0;
                    evt.frame_end = 1'b1;
                end else begin
                    r_d.ph        = 1'b0;
                    r_d.per       = r_q.per + 1'b1;
                    r_d.strobe    = 1'b0;
                    evt.slot_edge = 1'b1;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= SEQ_IDLE;
            r_q.ph     <= 1'b0;
            r_q.per    <= '0;
            r_q.strobe <= 1'b0;
            r_q.go     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st == SEQ_CONV);
    assign sclk_out   = r_q.ph;
    assign sstrb      = r_q.strobe;
    assign conv_start = r_q.go;

endmodule

// File: rtl/sps_dpath.sv
module sps_dpath
    import sps_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  seq_evt_t evt,
    input  logic     bit_valid,
    input  logic     bit_val,
    output logic     dout
);

    typedef struct packed {
        logic pend;   // most recently decided bit
        logic dout;
    } dp_t;

    dp_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (evt.frame_start) begin
            r_d.pend = 1'b0;
            r_d.dout = 1'b0;
        end else begin
            if (bit_valid) begin
                r_d.pend = bit_val;
            end
            if (evt.slot_edge) begin
                // a bit decided on this very edge goes straight out
                r_d.dout = bit_valid ? bit_val : r_q.pend;
            end else if (evt.frame_end) begin
                r_d.dout = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout = r_q.dout;

endmodule

// File: rtl/sar_serial_tx.sv
module sar_serial_tx
    import sps_pkg::*;
#(
    parameter int NBITS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic hben,
    input  logic bit_valid,
    input  logic bit_val,
    output logic conv_start,
    output logic dout,
    output logic dout_oe,
    output logic sclk_out,
    output logic sclk_oe,
    output logic sstrb,
    output logic sstrb_oe
);

    logic     busy;
    logic     start;
    seq_evt_t evt;

    sps_start_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .busy  (busy),
        .start (start)
    );

    sps_seq #(.NBITS(NBITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .hben       (hben),
        .cs_n       (cs_n),
        .busy       (busy),
        .sclk_out   (sclk_out),
        .sstrb      (sstrb),
        .conv_start (conv_start),
        .evt        (evt)
    );

    sps_dpath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .dout      (dout)
    );

    // Pad enables follow the select pins without a clock
    always_comb begin
        dout_oe  = ~cs_n;
        sclk_oe  = ~cs_n & ~rd_n;
        sstrb_oe = ~cs_n & ~rd_n;
    end

endmodule

// File: rtl/sar_serial_tx_chk.sv
module sar_serial_tx_chk #(
    parameter int NBITS = 12
) (
    input logic clk,
    input logic rst_n,
    input logic hben,
    input logic cs_n,
    input logic busy,
    input logic conv_start,
    input logic sclk_out,
    input logic sstrb,
    input logic dout,
    input logic dout_oe,
    input logic sclk_oe
);

    localparam int FRAME_CYC = 2 * (NBITS + 1);
    localparam int CW = $clog2(FRAME_CYC + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R1: start pulse lasts one cycle and follows a low select
    a_r1_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    a_r1_start_needs_low_cs: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(cs_n));

    // R2: strobe rises only together with a low serial clock
    a_r2_strobe_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sstrb) |-> !sclk_out);

    // R3: serial clock alternates through a running frame
    a_r3_sclk_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (sclk_out != $past(sclk_out)));

    // R5: data line quiet during strobe and between frames
    a_r5_dout_quiet_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sstrb |-> !dout);
    a_r5_dout_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dout);

    // R6: gated serial clock stays low between frames
    a_r6_sclk_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!hben && !busy) |=> !sclk_out);

    // R7: clock enable never without data enable
    always_comb begin
        a_r7_clk_en_implies_data_en: assert (!sclk_oe || dout_oe);
    end

    // R8: no start while a frame is in progress
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !conv_start);

    // R10: a frame lasts exactly 13 bit periods
    a_r10_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CW'(FRAME_CYC)));

    // cs_n is only observed so that every port of the checker is used
    logic unused_cs;
    assign unused_cs = cs_n;

endmodule

bind sar_serial_tx sar_serial_tx_chk #(.NBITS(NBITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hben       (hben),
    .cs_n       (cs_n),
    .busy       (busy),
    .conv_start (conv_start),
    .sclk_out   (sclk_out),
    .sstrb      (sstrb),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .sclk_oe    (sclk_oe)
);

// File: tb/tb_sar_serial_tx.sv
module tb_sar_serial_tx;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {word[11:0], hben, rd_n, bypass, bounce}
    localparam logic [15:0] VECS [NVEC] = '{
        {12'hA5C, 1'b0, 1'b0, 1'b0, 1'b0},
        {12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0},
        {12'h000, 1'b0, 1'b1, 1'b1, 1'b0},
        {12'h801, 1'b1, 1'b0, 1'b1, 1'b0},
        {12'h3C6, 1'b0, 1'b0, 1'b0, 1'b1},
        {12'h555, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic rd_n = 1'b0;
    logic hben = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_val = 1'b0;
    logic conv_start, dout, dout_oe, sclk_out, sclk_oe, sstrb, sstrb_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_serial_tx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .hben       (hben),
        .bit_valid  (bit_valid),
        .bit_val    (bit_val),
        .conv_start (conv_start),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .sclk_out   (sclk_out),
        .sclk_oe    (sclk_oe),
        .sstrb      (sstrb),
        .sstrb_oe   (sstrb_oe)
    );

    task automatic chk(input string req, input int k, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s step=%0d actual=%0b expected=%0b", req, k, act, exp);
        end
    endtask

    task automatic check_oe(input int k);
        chk("R7", k, dout_oe, ~cs_n);
        chk("R7", k, sclk_oe, ~cs_n & ~rd_n);
        chk("R7", k, sstrb_oe, ~cs_n & ~rd_n);
    endtask

    task automatic run_conv(input logic [11:0] word, input logic hb, input logic rd,
                            input logic byp, input logic bnc);
        hben = hb;
        rd_n = rd;
        cs_n = 1'b1;
        bit_valid = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (k < 26) begin
                int p = k / 2;
                chk("R3", k, sclk_out, 1'(k % 2));
                chk("R2", k, sstrb, p == 0);
                chk("R1", k, conv_start, k == 0);
                if (p >= 1) chk("R4", k, dout, word[12 - p]);
                else        chk("R5", k, dout, 1'b0);
                if (bnc) chk("R8", k, sstrb, p == 0);
            end else begin
                chk("R10", k, sstrb, 1'b0);
                chk("R5", k, dout, 1'b0);
                chk("R6", k, sclk_out, hb ? 1'((k - 26) % 2) : 1'b0);
                chk("R8", k, conv_start, 1'b0);
            end
            check_oe(k);
            // drive the decided bits for the next edge
            bit_valid = 1'b0;
            if (!byp && (k % 2 == 0) && (k / 2 < 12)) begin
                bit_valid = 1'b1;
                bit_val = word[11 - k / 2];
            end
            if (byp && (k % 2 == 1) && ((k - 1) / 2 < 12)) begin
                bit_valid = 1'b1;
                bit_val = word[11 - (k - 1) / 2];
            end
            if (bnc && k == 6) cs_n = 1'b1;
            if (bnc && k == 8) cs_n = 1'b0;
        end
        bit_valid = 1'b0;
        cs_n = 1'b1;
        #1;
        check_oe(99);
        chk("R7", 99, dout_oe, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", 0, conv_start, 1'b0);
        chk("R9", 0, dout, 1'b0);
        chk("R9", 0, sclk_out, 1'b0);
        chk("R9", 0, sstrb, 1'b0);
        check_oe(0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6", 1, sclk_out, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            run_conv(VECS[v][15:4], VECS[v][3], VECS[v][2], VECS[v][1], VECS[v][0]);
        end

        // R9: reset in the middle of a frame
        hben = 1'b0;
        cs_n = 1'b0;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9", 1, sclk_out, 1'b0);
        chk("R9", 1, sstrb, 1'b0);
        chk("R9", 1, dout, 1'b0);
        chk("R9", 1, conv_start, 1'b0);
        cs_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: a fresh frame after the abandoned one
        run_conv(12'h9A3, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule